// File: doc/BRIEF.md
# Streaming Segment-Test Corner Detector

This block finds corner features in a raster image stream while the pixels are still arriving. Each input beat carries four horizontally adjacent 8-bit pixels of one image row. The block keeps the six previous rows in a rolling line store. Together with the live row, this gives seven rows, from which it cuts four overlapping 7x7 neighbourhoods per beat. For each neighbourhood it compares the 16 pixels on a radius-3 ring with the middle pixel. A pixel is a corner candidate when an unbroken run of at least nine ring pixels is all clearly brighter, or all clearly darker, than the middle pixel. Bright and dark runs are tested in the same pass.

Every input beat produces exactly one output beat after a fixed delay, and each output beat carries a candidate flag and an 8-bit strength score for each of the four lanes. The output for a beat describes the pixel three rows above and three columns to the left of the beat's pixel, so that the whole neighbourhood is available before a decision is made. A contrast threshold is taken from a configuration input once per frame. Non-maximal suppression and any packing of results are left to downstream logic. The image width is a parameter and must be a multiple of four.

Top module: `seg_corner_detector`

## Requirements
- R1: Lane l of `in_pix` (bits 8l+7..8l) is the pixel at column 4w+l, where w counts the accepted beats of the current row from 0. A beat is accepted on any rising edge with `in_valid` high, and idle cycles between beats change no result. The column counter wraps to 0 and the row counter advances after IMG_W/4 accepted beats. A beat with `in_sof` high is row 0, column block 0.
- R2: A beat accepted at edge E produces one output beat visible after edge E+2. `out_valid`, `out_sof` and `out_eol` repeat `in_valid`, `in_sof` and `in_eol` of that beat.
- R3: Output lane l of the beat at row r and column c = 4w+l reports on the centre pixel at row r-3 and column c-3.
- R4: The ring has 16 entries in a fixed order, with offsets (dx,dy) and dy growing downward: (0,-3) (1,-3) (2,-2) (3,-1) (3,0) (3,1) (2,2) (1,3) (0,3) (-1,3) (-2,2) (-3,1) (-3,0) (-3,-1) (-2,-2) (-1,-3). Entry 15 is adjacent to entry 0.
- R5: A ring entry p passes bright when p - centre > T and passes dark when centre - p > T, where T is the frame threshold. Both comparisons are strict, so a difference equal to T passes neither way.
- R6: The centre is a candidate (`out_cand[l]`=1) when some run of 9 consecutive ring entries, counted around the ring including runs that cross from entry 15 to entry 0, passes entirely bright or entirely dark.
- R7: The score of a qualifying run is the smallest |p - centre| in the run minus T. `out_score` lane l is the largest such value over all qualifying runs. It is 0 when the lane is not a candidate, and no candidate is flagged on a beat without `out_valid`.
- R8: A centre in row 0..2 or column 0..2 of the frame is never flagged. Centres in the last three rows or columns are never reported at all, by R3.
- R9: T is the value of `cfg_thresh` on the beat carrying `in_sof`. Changes to `cfg_thresh` on any other beat or cycle have no effect on the frame.
- R10: While `rst` is high and after it falls, `out_valid` and all `out_cand` bits are 0 until data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eol | input | 1 | Beat is the last of a row |
| in_pix | input | 32 | Four adjacent 8-bit pixels, lane 0 leftmost |
| cfg_thresh | input | 8 | Contrast threshold, sampled with start of frame |
| out_valid | output | 1 | Output beat present |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_eol | output | 1 | Delayed end-of-row marker |
| out_cand | output | 4 | Candidate flag per lane |
| out_score | output | 32 | 8-bit score per lane, lane 0 in bits 7..0 |

## Verification
The assertions check on every cycle that the output marker pipeline keeps a fixed three-register delay behind the input. They also check that flags never appear without `out_valid`, that a flag and a non-zero score always come together, and that no ring entry can pass both directions or pass with zero margin. The bench alone can show that the right neighbourhood is selected from the line store: ring order, runs that wrap past entry 15, the strict threshold edge, border masking, the once-per-frame threshold capture and tolerance to idle cycles. It shows these by comparing every lane of every output beat with an arithmetic model over several synthetic frames.

// File: rtl/corner_pkg.sv
package corner_pkg;

    localparam int PIX_W  = 8;
    localparam int RING_N = 16;
    localparam int ARC_N  = 9;
    localparam int RAD    = 3;

    typedef logic [PIX_W-1:0] pix_t;
    typedef pix_t [RING_N-1:0] ring_t;

    // Neighbourhood sample handed from the window stage to the compare stage.
    typedef struct packed {
        ring_t ring;
        pix_t  ctr;
        pix_t  thr;
        logic  ok;
    } samp_t;

    // Per-entry direction flags and margins above threshold.
    typedef struct packed {
        logic [RING_N-1:0] brt;
        logic [RING_N-1:0] drk;
        ring_t             mag;
        logic              ok;
    } cmp_t;

    typedef struct packed {
        logic vld;
        logic sof;
        logic eol;
    } tag_t;

    // Ring offsets, clockwise from straight up; order defines contiguity.
    function automatic int ring_dx(input int k);
        case (k)
            0, 8:           return 0;
            1, 7:           return 1;
            2, 6:           return 2;
            3, 4, 5:        return 3;
            9, 15:          return -1;
            10, 14:         return -2;
            default:        return -3;
        endcase
    endfunction

    function automatic int ring_dy(input int k);
        case (k)
            0, 1, 15:       return -3;
            2, 14:          return -2;
            3, 13:          return -1;
            4, 12:          return 0;
            5, 11:          return 1;
            6, 10:          return 2;
            default:        return 3;
        endcase
    endfunction

endpackage

// File: rtl/corner_window.sv
module corner_window
    import corner_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IMG_W = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eol,
    input  logic [LANES*PIX_W-1:0]  in_pix,
    input  logic [PIX_W-1:0]        cfg_thresh,
    output samp_t [LANES-1:0]       smp_o,
    output tag_t                    tag_o
);
    localparam int WORDS  = IMG_W / LANES;
    localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LINES  = 2 * RAD;
    localparam int ROWS   = LINES + 1;
    localparam int HB     = (LINES + LANES - 1) / LANES;
    localparam int SPAN   = (HB + 1) * LANES;
    localparam int ROW_W  = $clog2(ROWS + 1);

    typedef pix_t [LANES-1:0] beat_t;
    typedef beat_t [ROWS-1:0] col_t;

    beat_t [LINES-1:0] mem [WORDS];
    col_t              hist [HB];
    col_t              cur;
    pix_t              win [ROWS][SPAN];

    logic [AW-1:0]     w_q, cur_w;
    logic [ROW_W-1:0]  row_q, cur_row;
    pix_t              thr_q, thr_now;
    samp_t [LANES-1:0] nxt, smp_q;
    tag_t              tag_q;

    always_comb begin
        cur_w   = in_sof ? '0 : w_q;
        cur_row = in_sof ? '0 : row_q;
        thr_now = in_sof ? cfg_thresh : thr_q;
    end

    // Seven-row column block: six stored rows plus the live input row.
    always_comb begin
        for (int r = 0; r < LINES; r++) cur[r] = mem[cur_w][r];
        cur[LINES] = beat_t'(in_pix);
    end

    // Horizontal span: HB past column blocks (oldest leftmost) then the live one.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            for (int b = 0; b <= HB; b++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (b == HB) win[r][b*LANES+l] = cur[r][l];
                    else         win[r][b*LANES+l] = hist[HB-1-b][r][l];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            for (int k = 0; k < RING_N; k++) begin
                nxt[l].ring[k] = win[RAD + ring_dy(k)][HB*LANES + l - RAD + ring_dx(k)];
            end
            nxt[l].ctr = win[RAD][HB*LANES + l - RAD];
            nxt[l].thr = thr_now;
            nxt[l].ok  = in_valid && (cur_row == ROW_W'(LINES)) &&
                         ((int'(cur_w) * LANES + l) >= LINES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q   <= '0;
            row_q <= '0;
            thr_q <= '0;
            smp_q <= '0;
            tag_q <= '0;
        end else begin
            smp_q <= nxt;
            tag_q <= '{vld: in_valid, sof: in_valid && in_sof, eol: in_valid && in_eol};
            if (in_valid) begin
                thr_q <= thr_now;
                if (cur_w == AW'(WORDS - 1)) begin
                    w_q   <= '0;
                    row_q <= (cur_row == ROW_W'(LINES)) ? cur_row : cur_row + 1'b1;
                end else begin
                    w_q   <= cur_w + 1'b1;
                    row_q <= cur_row;
                end
            end
        end
    end

    // Line store and column history carry no reset; border masking hides stale rows.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            mem[cur_w] <= cur[ROWS-1:1];
            hist[0]    <= cur;
            for (int h = 1; h < HB; h++) hist[h] <= hist[h-1];
        end
    end

    assign smp_o = smp_q;
    assign tag_o = tag_q;

endmodule

// File: rtl/corner_diff.sv
module corner_diff
    import corner_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  samp_t smp_i,
    output cmp_t  cmp_o
);
    cmp_t              nxt, cmp_q;
    logic [RING_N-1:0] mag_nz;

    always_comb begin
        pix_t absd;
        logic below;
        nxt    = '0;
        nxt.ok = smp_i.ok;
        for (int k = 0; k < RING_N; k++) begin
            below = smp_i.ring[k] < smp_i.ctr;
            absd  = below ? (smp_i.ctr - smp_i.ring[k]) : (smp_i.ring[k] - smp_i.ctr);
            if (absd > smp_i.thr) begin
                nxt.mag[k] = absd - smp_i.thr;
                nxt.brt[k] = !below;
                nxt.drk[k] = below;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmp_q <= '0;
        else     cmp_q <= nxt;
    end

    assign cmp_o = cmp_q;

    always_comb begin
        for (int k = 0; k < RING_N; k++) mag_nz[k] = (cmp_q.mag[k] != '0);
    end

    // R5: an entry never passes both directions at once
    p_dir_excl_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_q.brt & cmp_q.drk) == '0);

    // R5: a passing entry always clears the threshold by at least one step
    p_pass_margin_r5: assert property (@(posedge clk) disable iff (rst)
        ((cmp_q.brt | cmp_q.drk) & ~mag_nz) == '0);

endmodule

// File: rtl/corner_arc.sv
module corner_arc
    import corner_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmp_t cmp_i,
    output logic cand_o,
    output pix_t score_o
);
    logic any_arc;
    pix_t best;
    logic cand_q;
    pix_t score_q;

    // Every start position, wrapping past the last ring entry.
    always_comb begin
        logic ab;
        logic ad;
        pix_t mn;
        int   k;
        any_arc = 1'b0;
        best    = '0;
        for (int s = 0; s < RING_N; s++) begin
            ab = 1'b1;
            ad = 1'b1;
            mn = '1;
            for (int j = 0; j < ARC_N; j++) begin
                k  = (s + j) % RING_N;
                ab = ab & cmp_i.brt[k];
                ad = ad & cmp_i.drk[k];
                if (cmp_i.mag[k] < mn) mn = cmp_i.mag[k];
            end
            if (ab || ad) begin
                any_arc = 1'b1;
                if (mn > best) best = mn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q  <= 1'b0;
            score_q <= '0;
        end else begin
            cand_q  <= cmp_i.ok && any_arc;
            score_q <= (cmp_i.ok && any_arc) ? best : '0;
        end
    end

    assign cand_o  = cand_q;
    assign score_o = score_q;

    // R7: a flagged lane always carries a non-zero score
    p_cand_scored_r7: assert property (@(posedge clk) disable iff (rst)
        cand_q |-> (score_q != '0));

    // R7: an unflagged lane reports zero score
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !cand_q |-> (score_q == '0));

endmodule

// File: rtl/seg_corner_detector.sv
module seg_corner_detector
    import corner_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IMG_W = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic                   in_eol,
    input  logic [LANES*PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0]       cfg_thresh,
    output logic                   out_valid,
    output logic                   out_sof,
    output logic                   out_eol,
    output logic [LANES-1:0]       out_cand,
    output logic [LANES*PIX_W-1:0] out_score
);
    samp_t [LANES-1:0] smp;
    cmp_t  [LANES-1:0] cmp;
    tag_t              tag1, tag2, tag3;
    logic [1:0]        warm_q;

    corner_window #(.LANES(LANES), .IMG_W(IMG_W)) u_window (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eol     (in_eol),
        .in_pix     (in_pix),
        .cfg_thresh (cfg_thresh),
        .smp_o      (smp),
        .tag_o      (tag1)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        corner_diff u_diff (
            .clk   (clk),
            .rst   (rst),
            .smp_i (smp[l]),
            .cmp_o (cmp[l])
        );
        corner_arc u_arc (
            .clk     (clk),
            .rst     (rst),
            .cmp_i   (cmp[l]),
            .cand_o  (out_cand[l]),
            .score_o (out_score[l*PIX_W +: PIX_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag2   <= '0;
            tag3   <= '0;
            warm_q <= '0;
        end else begin
            tag2   <= tag1;
            tag3   <= tag2;
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        end
    end

    assign out_valid = tag3.vld;
    assign out_sof   = tag3.sof;
    assign out_eol   = tag3.eol;

    // R2: output beats follow input beats by a fixed delay
    p_beat_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2: frame marker travels with its beat
    p_sof_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (out_sof == $past(in_valid && in_sof, 3)));

    // R7: no flag on an empty output slot
    p_cand_in_beat_r7: assert property (@(posedge clk) disable iff (rst)
        (out_cand != '0) |-> out_valid);

endmodule

// File: tb/seg_corner_detector_tb.sv
module seg_corner_detector_tb;
    localparam int LANES = 4;
    localparam int W     = 16;
    localparam int H     = 10;
    localparam int WORDS = W / LANES;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_sof = 1'b0;
    logic               in_eol = 1'b0;
    logic [LANES*8-1:0] in_pix = '0;
    logic [7:0]         cfg_thresh = '0;
    logic               out_valid, out_sof, out_eol;
    logic [LANES-1:0]   out_cand;
    logic [LANES*8-1:0] out_score;

    seg_corner_detector #(.LANES(LANES), .IMG_W(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
        .in_pix(in_pix), .cfg_thresh(cfg_thresh), .out_valid(out_valid),
        .out_sof(out_sof), .out_eol(out_eol), .out_cand(out_cand), .out_score(out_score)
    );

    always #10 clk = ~clk;

    int    nchk = 0;
    int    nfail = 0;
    int    cyc = 0;
    int    img [H][W];
    int    in_cyc [H*WORDS];
    int    frame_thr = 0;
    string frame_tag = "R3";
    int    out_idx = 0;
    int    out_cnt = 0;
    bit    done = 1'b0;

    int odx [16] = '{0, 1, 2, 3, 3, 3, 2, 1, 0, -1, -2, -3, -3, -3, -2, -1};
    int ody [16] = '{-3, -3, -2, -1, 0, 1, 2, 3, 3, 3, 2, 1, 0, -1, -2, -3};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Arithmetic model of the segment test for centre (r,c).
    function automatic void ref_px(input int r, input int c, input int t, output int score);
        int d [16];
        int ctr;
        ctr   = img[r][c];
        score = 0;
        for (int k = 0; k < 16; k++) d[k] = img[r + ody[k]][c + odx[k]] - ctr;
        for (int s = 0; s < 16; s++) begin
            bit ab;
            bit ad;
            int mn;
            ab = 1; ad = 1; mn = 1000;
            for (int j = 0; j < 9; j++) begin
                int k;
                int a;
                k = (s + j) % 16;
                if (!(d[k] > t))  ab = 0;
                if (!(-d[k] > t)) ad = 0;
                a = (d[k] < 0 ? -d[k] : d[k]) - t;
                if (a < mn) mn = a;
            end
            if ((ab || ad) && mn > score) score = mn;
        end
    endfunction

    function automatic int hashpix(input int f, input int r, input int c);
        return ((r * 37 + c * 91 + f * 53) ^ (r * c * 13) ^ (c * c * 7)) & 255;
    endfunction

    // Output monitor: compares every lane of every output beat.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int r;
            int w;
            if (out_sof) out_idx = 0;
            r = out_idx / WORDS;
            w = out_idx % WORDS;
            chk(out_sof == (out_idx == 0), "R2", "sof marker", out_sof, out_idx == 0);
            chk(out_eol == (w == WORDS - 1), "R2", "eol marker", out_eol, w == WORDS - 1);
            chk(cyc == in_cyc[out_idx] + 3, "R2", "beat latency", cyc - in_cyc[out_idx], 3);
            for (int l = 0; l < LANES; l++) begin
                int c;
                int es;
                bit okpos;
                c     = w * LANES + l;
                okpos = (r >= 6) && (c >= 6);
                es    = 0;
                if (okpos) ref_px(r - 3, c - 3, frame_thr, es);
                if (!okpos)
                    chk(out_cand[l] == 1'b0, "R8", "border flag", out_cand[l], 0);
                else
                    chk(out_cand[l] == (es > 0), frame_tag, "cand (R6)", out_cand[l], es > 0);
                chk(int'(out_score[l*8 +: 8]) == es, okpos ? frame_tag : "R8",
                    "score (R7)", out_score[l*8 +: 8], es);
            end
            out_idx++;
            out_cnt++;
        end
    end

    task automatic send_frame(input int thr, input bit bubbles, input bit thr_mix, input string tag);
        int beat;
        frame_thr = thr;
        frame_tag = tag;
        out_cnt   = 0;
        beat      = 0;
        cfg_thresh = 8'((thr + 77) & 255);
        for (int r = 0; r < H; r++) begin
            for (int w = 0; w < WORDS; w++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof   = (beat == 0);
                in_eol   = (w == WORDS - 1);
                for (int l = 0; l < LANES; l++) in_pix[l*8 +: 8] = 8'(img[r][w*LANES + l]);
                if (beat == 0)    cfg_thresh = 8'(thr);
                else if (thr_mix) cfg_thresh = 8'((thr + beat * 29 + 3) & 255);
                in_cyc[beat] = cyc;
                beat++;
                if (bubbles && (beat % 3 == 0)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_sof   = 1'b0;
                    in_eol   = 1'b0;
                    in_pix   = '1;
                    cfg_thresh = 8'hFF;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
        repeat (6) @(negedge clk);
        chk(out_cnt == H * WORDS, "R2", "output beats per frame", out_cnt, H * WORDS);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "valid in reset", out_valid, 0);
        chk(out_cand == '0, "R10", "cand in reset", out_cand, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "valid after reset", out_valid, 0);
        chk(out_cand == '0, "R10", "cand after reset", out_cand, 0);
        chk(out_score == '0, "R10", "score after reset", out_score, 0);

        // Mixed noise, moderate threshold.
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = hashpix(1, r, c);
        send_frame(30, 1'b0, 1'b0, "R3");

        // Noise, zero threshold, idle cycles between beats.
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = hashpix(2, r, c);
        send_frame(0, 1'b1, 1'b0, "R1");

        // Bright quadrant corner, threshold input wobbling mid-frame.
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++)
            img[r][c] = (r >= 5 && c >= 7) ? 200 : 50;
        send_frame(40, 1'b0, 1'b1, "R9");

        // Flat field with dots at and just past the threshold.
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = 100;
        img[4][5]  = 120;
        img[5][10] = 121;
        img[6][8]  = 79;
        send_frame(20, 1'b0, 1'b0, "R5");

        // Dark hole under a bright band: qualifying run crosses entry 15 to entry 0.
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = (r <= 5) ? 200 : 50;
        img[5][7] = 50;
        send_frame(25, 1'b0, 1'b0, "R4");

        // Noise, low threshold, bubbles and threshold wobble together.
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = hashpix(5, r, c);
        send_frame(10, 1'b1, 1'b1, "R9");

        // Flat field, zero threshold: equal pixels never pass.
        for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) img[r][c] = 77;
        send_frame(0, 1'b0, 1'b0, "R6");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

endmodule